// File: doc/BRIEF.md
# Soft-stepping PGA gain controller

This block holds the applied gain of a microphone preamplifier and moves it toward a requested setting. The requested setting is a 7-bit code in half-decibel units, from 0 dB at code 0 up to 59.5 dB at code 119. A 2-bit input-scaling selector shifts that code up or down by 6 dB, which is 12 codes. With soft-stepping on, the applied gain moves by one code on each step-tick strobe. With soft-stepping off, it loads the effective target in a single cycle. Mute is kept as its own gain state, one rank below code 0. Ramps therefore pass through 0 dB on their way into or out of mute.

A small power sequencer handles shutdown. When the power request drops, the gain ramps down to mute. The power-up status stays high until mute has been reached, and then a one-cycle done pulse is issued. Only after that pulse may the clock be stopped. A sample register on the digital path stops updating while the applied gain is muted, so the output holds its last value. A status output reports when the applied gain matches the gain currently wanted.

Top module: `pga_softstep_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the applied gain is mute, `pwr_up` and `pd_done` are 0 and `sample_out` is 0.
- R2: With `step_off` low, the applied gain moves exactly one rank toward the wanted gain on each clock where `step_tick` is high. It does not change on a clock where `step_tick` is low. The ranks in order are mute, code 0, code 1, and so on up to code 119.
- R3: With `step_off` high, the applied gain equals the wanted gain one clock later.
- R4: The effective target is computed in two stages. First, a `tgt_code` above 119 is clamped to 119. Then `scale_sel` is applied: 2'b01 adds 12, 2'b11 subtracts 12, and 2'b10 or 2'b00 adds nothing. The result is saturated to the range 0 to 119.
- R5: With `amp_en` low (and not muted, and powered), the wanted gain is code 0 (0 dB, not muted).
- R6: With `mute_req` high, the wanted gain is mute. A ramp out of mute passes through code 0 first.
- R7: `gain_reached` is 1 exactly when the applied gain equals the wanted gain, and this includes the case where both are mute.
- R8: If the target changes in the middle of a ramp, the next step already moves toward the new target.
- R9: When `pwr_req` falls, the gain ramps to mute. `pwr_up` stays 1 until the clock after the applied gain has reached mute. At that clock `pwr_up` goes to 0 and `pd_done` pulses high for exactly one clock.
- R10: While the applied gain is mute, `sample_out` keeps its value. Otherwise it takes `sample_in` with one clock of latency.
- R11: While `pwr_up` is 0, the wanted gain is mute whatever the other inputs are. A rising `pwr_req` sets `pwr_up` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power request; falling edge starts ramp-to-mute shutdown |
| amp_en | input | 1 | Amplifier enable; low forces 0 dB |
| mute_req | input | 1 | Mute request |
| step_off | input | 1 | 1 disables soft-stepping (immediate load) |
| step_tick | input | 1 | Step strobe, one rank per high clock |
| scale_sel | input | 2 | Input scaling: 01 +12, 10 none, 11 -12, 00 none |
| tgt_code | input | 7 | Requested gain code, 0.5 dB units |
| sample_in | input | SAMPLE_W | Digital sample input |
| gain_code | output | 7 | Applied gain code (0 while muted) |
| gain_muted | output | 1 | Applied gain is in the mute state |
| gain_reached | output | 1 | Applied gain equals wanted gain |
| pwr_up | output | 1 | Power-up status |
| pd_done | output | 1 | One-clock pulse when shutdown completes |
| sample_out | output | SAMPLE_W | Held or passed sample |

## Verification
Several rules are checked by assertions on every clock. The applied gain never moves by more than one rank while stepping is on, and it never moves without a tick. It loads the wanted gain in one clock when stepping is off. The wanted code stays within range. The done flag is always a single-clock pulse. Power status holds while the ramp is unfinished. An unpowered block is always muted. The held sample stays frozen while muted. Other behaviours need the bench's scenarios: the exact scaled target values and their saturation corners, the mid-ramp redirect, passing through 0 dB when leaving mute, and the full shutdown timeline from the power request falling to the done pulse.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int CODE_W      = 7;
    localparam int MAX_CODE    = 119;
    localparam int SHIFT_STEPS = 12;

    typedef struct packed {
        logic              muted;
        logic [CODE_W-1:0] code;
    } gain_t;

    localparam gain_t GAIN_MUTE = '{muted: 1'b1, code: '0};
    localparam gain_t GAIN_ZERO = '{muted: 1'b0, code: '0};

    typedef enum logic [1:0] {
        SCL_NONE  = 2'b00,
        SCL_UP    = 2'b01,
        SCL_UNITY = 2'b10,
        SCL_DOWN  = 2'b11
    } scale_e;

    typedef enum logic [1:0] {
        PWR_OFF    = 2'b00,
        PWR_ON     = 2'b01,
        PWR_RAMPDN = 2'b10
    } pwr_e;

    // Clamp the request, apply the scaling offset, saturate.
    function automatic gain_t scaled_target(logic [CODE_W-1:0] req, scale_e s);
        int    base;
        int    v;
        gain_t g;
        base = (int'(req) > MAX_CODE) ? MAX_CODE : int'(req);
        case (s)
            SCL_UP:   v = base + SHIFT_STEPS;
            SCL_DOWN: v = base - SHIFT_STEPS;
            default:  v = base;
        endcase
        if (v < 0)        v = 0;
        if (v > MAX_CODE) v = MAX_CODE;
        g.muted = 1'b0;
        g.code  = CODE_W'(v);
        return g;
    endfunction

    // Mute is rank 0, code n is rank n+1.
    function automatic int gain_rank(gain_t g);
        return g.muted ? 0 : int'(g.code) + 1;
    endfunction

    function automatic gain_t rank_to_gain(int r);
        gain_t g;
        if (r <= 0) begin
            g = GAIN_MUTE;
        end else begin
            g.muted = 1'b0;
            g.code  = CODE_W'(r - 1);
        end
        return g;
    endfunction

endpackage

// File: rtl/pga_target.sv
module pga_target
    import pga_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              amp_en,
    input  logic              mute_req,
    input  scale_e            scale,
    input  pwr_e              pwr_state,
    output gain_t             desired
);

    always_comb begin
        if (pwr_state != PWR_ON || mute_req) begin
            desired = GAIN_MUTE;
        end else if (!amp_en) begin
            desired = GAIN_ZERO;
        end else begin
            desired = scaled_target(tgt_code, scale);
        end
    end

    // R4: wanted code never leaves the legal range
    p_target_range_r4: assert property (@(posedge clk) disable iff (rst)
        !desired.muted |-> (int'(desired.code) <= MAX_CODE));

    // R11: unpowered block always wants mute
    p_unpowered_mute_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_OFF) |-> desired.muted);

endmodule

// File: rtl/pga_ramp.sv
module pga_ramp
    import pga_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_off,
    input  logic  step_tick,
    input  gain_t desired,
    output gain_t applied
);

    int    cur_rank;
    int    want_rank;
    gain_t nxt;

    always_comb begin
        cur_rank  = gain_rank(applied);
        want_rank = gain_rank(desired);
        nxt       = applied;
        if (step_off) begin
            nxt = desired;
        end else if (step_tick) begin
            if (cur_rank < want_rank) begin
                nxt = rank_to_gain(cur_rank + 1);
            end else if (cur_rank > want_rank) begin
                nxt = rank_to_gain(cur_rank - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            applied <= GAIN_MUTE;
        end else begin
            applied <= nxt;
        end
    end

    // R2: no movement without a tick while stepping
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!step_off && !step_tick) |=> $stable(applied));

    // R2: at most one rank per clock while stepping
    p_one_rank_r2: assert property (@(posedge clk) disable iff (rst)
        !step_off |=> (cur_rank == $past(cur_rank) ||
                       cur_rank == $past(cur_rank) + 1 ||
                       cur_rank + 1 == $past(cur_rank)));

    // R3: immediate load when stepping is off
    p_direct_load_r3: assert property (@(posedge clk) disable iff (rst)
        step_off |=> (applied == $past(desired)));

endmodule

// File: rtl/pga_pwr_seq.sv
module pga_pwr_seq
    import pga_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_req,
    input  logic applied_muted,
    output pwr_e state,
    output logic pwr_up,
    output logic pd_done
);

    pwr_e nxt_state;

    always_comb begin
        nxt_state = state;
        case (state)
            PWR_OFF:    if (pwr_req)       nxt_state = PWR_ON;
            PWR_ON:     if (!pwr_req)      nxt_state = PWR_RAMPDN;
            PWR_RAMPDN: if (applied_muted) nxt_state = PWR_OFF;
            default:                       nxt_state = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PWR_OFF;
            pd_done <= 1'b0;
        end else begin
            state   <= nxt_state;
            pd_done <= (state == PWR_RAMPDN) && applied_muted;
        end
    end

    assign pwr_up = (state != PWR_OFF);

    // R9: power status holds while the ramp to mute is unfinished
    p_hold_power_r9: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_RAMPDN && !applied_muted) |=> pwr_up);

    // R9: done is a single-clock pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        pd_done |=> !pd_done);

    // R9: done coincides with power status dropping
    p_done_off_r9: assert property (@(posedge clk) disable iff (rst)
        pd_done |-> !pwr_up);

endmodule

// File: rtl/pga_hold.sv
module pga_hold #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                freeze,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SAMPLE_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (!freeze) begin
            dout <= din;
        end
    end

    // R10: output frozen while muted
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(dout));

endmodule

// File: rtl/pga_softstep_ctrl.sv
module pga_softstep_ctrl
    import pga_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_req,
    input  logic                amp_en,
    input  logic                mute_req,
    input  logic                step_off,
    input  logic                step_tick,
    input  logic [1:0]          scale_sel,
    input  logic [CODE_W-1:0]   tgt_code,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [CODE_W-1:0]   gain_code,
    output logic                gain_muted,
    output logic                gain_reached,
    output logic                pwr_up,
    output logic                pd_done,
    output logic [SAMPLE_W-1:0] sample_out
);

    gain_t desired;
    gain_t applied;
    pwr_e  pwr_state;

    pga_target u_target (
        .clk       (clk),
        .rst       (rst),
        .tgt_code  (tgt_code),
        .amp_en    (amp_en),
        .mute_req  (mute_req),
        .scale     (scale_e'(scale_sel)),
        .pwr_state (pwr_state),
        .desired   (desired)
    );

    pga_ramp u_ramp (
        .clk       (clk),
        .rst       (rst),
        .step_off  (step_off),
        .step_tick (step_tick),
        .desired   (desired),
        .applied   (applied)
    );

    pga_pwr_seq u_pwr (
        .clk           (clk),
        .rst           (rst),
        .pwr_req       (pwr_req),
        .applied_muted (applied.muted),
        .state         (pwr_state),
        .pwr_up        (pwr_up),
        .pd_done       (pd_done)
    );

    pga_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .freeze (applied.muted),
        .din    (sample_in),
        .dout   (sample_out)
    );

    assign gain_muted   = applied.muted;
    assign gain_code    = applied.muted ? '0 : applied.code;
    assign gain_reached = (applied == desired);

    // R11: an unpowered block is always muted
    p_off_muted_r11: assert property (@(posedge clk) disable iff (rst)
        !pwr_up |-> gain_muted);

endmodule

// File: tb/tb_pga_softstep_ctrl.sv
module tb_pga_softstep_ctrl;

    localparam int SW = 16;
    localparam int F_GAIN = 0, F_REACH = 1, F_PWR = 2, F_DONE = 3, F_SAMP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_req = 1'b0, amp_en = 1'b1, mute_req = 1'b0;
    logic          step_off = 1'b0, step_tick = 1'b0;
    logic [1:0]    scale_sel = 2'b10;
    logic [6:0]    tgt_code = '0;
    logic [SW-1:0] sample_in = '0;
    logic [6:0]    gain_code;
    logic          gain_muted, gain_reached, pwr_up, pd_done;
    logic [SW-1:0] sample_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 0;

    typedef struct {
        int    due;
        int    fld;
        int    val;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    pga_softstep_ctrl #(.SAMPLE_W(SW)) dut (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .amp_en(amp_en),
        .mute_req(mute_req), .step_off(step_off), .step_tick(step_tick),
        .scale_sel(scale_sel), .tgt_code(tgt_code), .sample_in(sample_in),
        .gain_code(gain_code), .gain_muted(gain_muted), .gain_reached(gain_reached),
        .pwr_up(pwr_up), .pd_done(pd_done), .sample_out(sample_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int actual(int f);
        case (f)
            F_GAIN:  return gain_muted ? -1 : int'(gain_code);
            F_REACH: return int'(gain_reached);
            F_PWR:   return int'(pwr_up);
            F_DONE:  return int'(pd_done);
            default: return int'(sample_out);
        endcase
    endfunction

    // Driver side: schedule an expectation k clock edges from now.
    task automatic expect_at(int k, int f, int v, string tag);
        item_t it;
        it.due = cyc + k; it.fld = f; it.val = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic adv(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Monitor side: compare due items away from the active edge.
    always @(negedge clk) begin
        int n;
        n = exp_q.size();
        for (int i = 0; i < n; i++) begin
            item_t it;
            it = exp_q.pop_front();
            if (it.due == cyc) begin
                total++;
                if (actual(it.fld) != it.val) begin
                    bad++;
                    $display("FAIL %s field=%0d cycle=%0d actual=%0d expected=%0d",
                             it.tag, it.fld, cyc, actual(it.fld), it.val);
                end
            end else begin
                exp_q.push_back(it);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        adv(3);
        // R1: reset state
        expect_at(1, F_GAIN, -1, "R1");
        expect_at(1, F_PWR, 0, "R1");
        expect_at(1, F_DONE, 0, "R1");
        expect_at(1, F_SAMP, 0, "R1");
        expect_at(1, F_REACH, 1, "R7");
        rst = 1'b0;
        adv(2);

        // R11 power-up, R2 no tick no move
        pwr_req = 1'b1; tgt_code = 7'd4;
        expect_at(1, F_PWR, 1, "R11");
        expect_at(1, F_GAIN, -1, "R2");
        expect_at(1, F_REACH, 0, "R7");
        expect_at(3, F_GAIN, -1, "R2");
        adv(3);

        // R6 leave mute through code 0, R2 one rank per tick
        step_tick = 1'b1;
        expect_at(1, F_GAIN, 0, "R6");
        expect_at(2, F_GAIN, 1, "R2");
        expect_at(4, F_GAIN, 3, "R2");
        expect_at(4, F_REACH, 0, "R7");
        expect_at(5, F_GAIN, 4, "R2");
        expect_at(5, F_REACH, 1, "R7");
        expect_at(7, F_GAIN, 4, "R2");
        adv(7);

        // R4 scaling up by 12 steps
        scale_sel = 2'b01;
        expect_at(11, F_GAIN, 15, "R2");
        expect_at(12, F_GAIN, 16, "R4");
        expect_at(14, F_GAIN, 16, "R4");
        adv(14);

        // R4 corners with direct load
        step_off = 1'b1; scale_sel = 2'b11;
        expect_at(1, F_GAIN, 0, "R4");
        adv(2);
        scale_sel = 2'b00;
        expect_at(1, F_GAIN, 4, "R4");
        adv(2);
        tgt_code = 7'd115; scale_sel = 2'b01;
        expect_at(1, F_GAIN, 119, "R4");
        adv(2);
        tgt_code = 7'd127; scale_sel = 2'b10;
        expect_at(1, F_GAIN, 119, "R4");
        adv(2);
        scale_sel = 2'b11;
        expect_at(1, F_GAIN, 107, "R4");
        adv(2);

        // R3 and R8 redirect mid-ramp
        tgt_code = 7'd10; scale_sel = 2'b10;
        expect_at(1, F_GAIN, 10, "R3");
        adv(2);
        step_off = 1'b0; tgt_code = 7'd20;
        expect_at(3, F_GAIN, 13, "R8");
        adv(3);
        tgt_code = 7'd5;
        expect_at(1, F_GAIN, 12, "R8");
        expect_at(2, F_GAIN, 11, "R8");
        adv(2);
        step_tick = 1'b0;
        expect_at(1, F_GAIN, 11, "R2");
        expect_at(3, F_GAIN, 11, "R2");
        adv(3);

        // R5 disabled amplifier gives 0 dB
        step_off = 1'b1; amp_en = 1'b0;
        expect_at(1, F_GAIN, 0, "R5");
        expect_at(1, F_REACH, 1, "R5");
        adv(2);
        amp_en = 1'b1; tgt_code = 7'd10;
        expect_at(1, F_GAIN, 10, "R3");
        adv(2);

        // R6 ramp to mute, R10 sample hold
        sample_in = 16'd100; step_off = 1'b0; step_tick = 1'b1; mute_req = 1'b1;
        expect_at(10, F_GAIN, 0, "R6");
        expect_at(11, F_GAIN, -1, "R6");
        expect_at(11, F_REACH, 1, "R7");
        expect_at(11, F_SAMP, 100, "R10");
        adv(12);
        sample_in = 16'd555;
        expect_at(1, F_SAMP, 100, "R10");
        expect_at(3, F_SAMP, 100, "R10");
        adv(3);
        mute_req = 1'b0;
        expect_at(1, F_GAIN, 0, "R6");
        expect_at(1, F_SAMP, 100, "R10");
        expect_at(2, F_GAIN, 1, "R6");
        expect_at(2, F_SAMP, 555, "R10");
        adv(2);

        // R9 stepped shutdown
        step_off = 1'b1; tgt_code = 7'd3;
        expect_at(1, F_GAIN, 3, "R3");
        adv(2);
        step_off = 1'b0; pwr_req = 1'b0;
        expect_at(4, F_GAIN, 0, "R9");
        expect_at(5, F_GAIN, -1, "R9");
        expect_at(5, F_PWR, 1, "R9");
        expect_at(5, F_DONE, 0, "R9");
        expect_at(6, F_PWR, 0, "R9");
        expect_at(6, F_DONE, 1, "R9");
        expect_at(7, F_DONE, 0, "R9");
        adv(8);

        // R11 unpowered stays muted
        step_off = 1'b1; tgt_code = 7'd50;
        expect_at(1, F_GAIN, -1, "R11");
        expect_at(3, F_GAIN, -1, "R11");
        expect_at(3, F_PWR, 0, "R11");
        adv(3);
        pwr_req = 1'b1;
        expect_at(1, F_PWR, 1, "R11");
        expect_at(2, F_GAIN, 50, "R3");
        adv(3);

        // R9 direct-load shutdown
        pwr_req = 1'b0;
        expect_at(2, F_GAIN, -1, "R9");
        expect_at(2, F_PWR, 1, "R9");
        expect_at(3, F_PWR, 0, "R9");
        expect_at(3, F_DONE, 1, "R9");
        expect_at(4, F_DONE, 0, "R9");
        adv(6);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule